// File: doc/BRIEF.md
# Reload-Triggered Clock Divider Bank

This block derives several slower clocks from one fast reference clock. Every output has its own divide ratio and its own gate. The block runs entirely in the reference clock domain and produces each divided clock as a registered waveform. A small register interface exposes two words. The control word holds the gate enables, the per-output reload-force requests, the global reload trigger and a sticky error flag. The ratio word holds one staged ratio field for each output.

Writing the ratio word only stages a value. Software must set the force bit of each output it wants to update and then raise the global reload bit. On the rising edge of that bit, every forced output whose staged field is legal latches it as its pending ratio. The output then switches to the pending ratio at the end of its current period. A staged value that is not legal is discarded and raises the error flag. A fixed companion output toggles on every rising edge of the output selected by `HALF_SRC` (output 1 by default), so it runs at half that output's frequency and shares its gate.

Top module: `cdiv_bank`

## Requirements
- R1: After reset, the control word at address 0x0 reads with only the enable bits set (bit 24+i for each output i). The force bits [7:0], the reload bit 8 and the error bit 31 read zero. The ratio word at 0x8 holds 8 in every field, every output divides by 8, and all outputs are low while reset is held.
- R2: An output running with ratio r repeats every r reference cycles. It is high for floor(r/2) cycles and low for the remaining cycles, which gives 2 high and 3 low for r=5 and 50 % duty for 4, 6 and 8. The ratio for output i is a plain binary value in the 6-bit field at bits [8i+5:8i] of the ratio word.
- R3: Writing the ratio word without a reload leaves every running output unchanged.
- R4: A rising edge of control bit 8 copies the staged field of output i to that output only when force bit i is set. Outputs whose force bit is clear keep their ratio.
- R5: A new ratio takes effect only after the current period has finished. No high or low phase shorter than the shorter of the old and new phases appears.
- R6: If the staged ratio of a forced output is not 4, 5, 6 or 8 at a reload, the output keeps its previous ratio and error bit 31 of the control word is set. That bit stays set until software writes the control word with bit 31 set.
- R7: Clearing the force bits and the reload bit after a reload leaves the newly applied ratio in effect.
- R8: When enable bit 24+i is clear, output i is held low from the next cycle onward. Setting the bit again starts a full high phase on the following cycle. Other outputs keep running.
- R9: `half_clk` toggles once for every rising edge of output `HALF_SRC`, so each of its phases lasts one full period of that output. It is held low while that output's enable bit is clear.
- R10: Addresses other than 0x0 and 0x8 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 4 | Byte address: 0x0 control, 0x8 ratio |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| div_clk | output | NUM_DIV | Divided clock outputs |
| half_clk | output | 1 | Half-rate companion of output `HALF_SRC` |
| ratio_err | output | 1 | Sticky illegal-ratio flag, also control bit 31 |

## Verification
The bench targets the gap between staging and applying a ratio. It writes the ratio word and checks that nothing changes without a reload, then checks that an output whose force bit is clear ignores the reload. A design that applied ratios on write, or ignored the force mask, would show the new period too early or on the wrong output. Across a ratio switch, the bench measures every phase length, because a design that reloaded its counter mid-period would emit a shortened pulse. It feeds an illegal ratio of 7, where a design without the legality check would divide by 7 and leave the flag clear. It also gates and re-enables the source of the companion output, where a wrong design would leave `half_clk` toggling or restart on a partial phase.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int RATIO_W    = 6;
  localparam int FIELD_W    = 8;
  localparam int EN_BASE    = 24;
  localparam int RELOAD_BIT = 8;
  localparam int ERR_BIT    = 31;
  localparam logic [3:0] CTRL_ADDR  = 4'h0;
  localparam logic [3:0] RATIO_ADDR = 4'h8;

  typedef logic [RATIO_W-1:0] ratio_t;

  localparam ratio_t RESET_RATIO = ratio_t'(8);

  function automatic logic ratio_ok(input ratio_t r);
    return (r == ratio_t'(4)) || (r == ratio_t'(5)) ||
           (r == ratio_t'(6)) || (r == ratio_t'(8));
  endfunction

  function automatic logic [31:0] ratio_word_reset(input int n);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < n; i++) w[i*FIELD_W +: RATIO_W] = RESET_RATIO;
    return w;
  endfunction
endpackage

// File: rtl/cdiv_channel.sv
module cdiv_channel
  import cdiv_pkg::*;
(
  input  logic   clk_ref,
  input  logic   rst_n,
  input  logic   en,
  input  ratio_t pend,
  output logic   div_out
);
  ratio_t app_q;
  ratio_t cnt_q;
  ratio_t cnt_nxt;
  ratio_t high_len;
  logic   wrap;

  assign high_len = app_q >> 1;
  assign wrap     = (cnt_q == app_q - ratio_t'(1));
  assign cnt_nxt  = cnt_q + ratio_t'(1);

  // The counter only wraps at the end of a full period; the pending ratio
  // is adopted only there, so no phase is ever cut short.
  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      app_q   <= RESET_RATIO;
      cnt_q   <= RESET_RATIO - ratio_t'(1);
      div_out <= 1'b0;
    end else if (!en) begin
      app_q   <= pend;
      cnt_q   <= pend - ratio_t'(1);
      div_out <= 1'b0;
    end else if (wrap) begin
      app_q   <= pend;
      cnt_q   <= '0;
      div_out <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      div_out <= (cnt_nxt < high_len);
    end
  end
endmodule

// File: rtl/cdiv_half.sv
module cdiv_half (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic en,
  input  logic src,
  output logic half_out
);
  logic src_d;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      src_d    <= 1'b0;
      half_out <= 1'b0;
    end else begin
      src_d <= src;
      if (!en) half_out <= 1'b0;
      else if (src && !src_d) half_out <= ~half_out;
    end
  end
endmodule

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int NUM_DIV = 2
) (
  input  logic                       clk_ref,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [3:0]                 addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [NUM_DIV-1:0]         en,
  output ratio_t [NUM_DIV-1:0]       pend,
  output logic                       err
);
  localparam logic [31:0] EN_MASK   = ((32'd1 << NUM_DIV) - 32'd1) << EN_BASE;
  localparam logic [31:0] CTRL_MASK = EN_MASK | 32'h0000_01FF;
  localparam logic [31:0] RATIO_RST = ratio_word_reset(NUM_DIV);

  logic [31:0]        ctrl_q;
  logic [31:0]        ratio_q;
  logic               rld_d;
  logic               reload_pulse;
  logic               ctrl_wr;
  logic               ratio_wr;
  logic [NUM_DIV-1:0] legal;
  logic [NUM_DIV-1:0] take;
  logic [NUM_DIV-1:0] bad;

  assign ctrl_wr      = wr && (addr == CTRL_ADDR);
  assign ratio_wr     = wr && (addr == RATIO_ADDR);
  assign reload_pulse = ctrl_q[RELOAD_BIT] && !rld_d;
  assign en           = ctrl_q[EN_BASE +: NUM_DIV];

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_field
    assign legal[i] = ratio_ok(ratio_q[i*FIELD_W +: RATIO_W]);
    assign take[i]  = reload_pulse && ctrl_q[i] && legal[i];
    assign bad[i]   = reload_pulse && ctrl_q[i] && !legal[i];
  end

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      ctrl_q  <= EN_MASK;
      ratio_q <= RATIO_RST;
      rld_d   <= 1'b0;
    end else begin
      if (ctrl_wr)  ctrl_q  <= wdata & CTRL_MASK;
      if (ratio_wr) ratio_q <= wdata;
      rld_d <= ctrl_q[RELOAD_BIT];
    end
  end

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DIV; i++) pend[i] <= RESET_RATIO;
    end else begin
      for (int i = 0; i < NUM_DIV; i++)
        if (take[i]) pend[i] <= ratio_q[i*FIELD_W +: RATIO_W];
    end
  end

  // Sticky error: a new illegal reload wins over a simultaneous clear.
  always_ff @(posedge clk_ref) begin
    if (!rst_n) err <= 1'b0;
    else if (|bad) err <= 1'b1;
    else if (ctrl_wr && wdata[ERR_BIT]) err <= 1'b0;
  end

  always_comb begin
    case (addr)
      CTRL_ADDR:  rdata = ctrl_q | ({31'd0, err} << ERR_BIT);
      RATIO_ADDR: rdata = ratio_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter int NUM_DIV  = 2,
  parameter int HALF_SRC = 1
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_DIV-1:0] div_clk,
  output logic               half_clk,
  output logic               ratio_err
);
  logic [NUM_DIV-1:0]   en_w;
  ratio_t [NUM_DIV-1:0] pend_w;

  cdiv_regs #(.NUM_DIV(NUM_DIV)) u_regs (
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .en      (en_w),
    .pend    (pend_w),
    .err     (ratio_err)
  );

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    cdiv_channel u_chan (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .en      (en_w[i]),
      .pend    (pend_w[i]),
      .div_out (div_clk[i])
    );
  end

  cdiv_half u_half (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .en       (en_w[HALF_SRC]),
    .src      (div_clk[HALF_SRC]),
    .half_out (half_clk)
  );
endmodule

// File: rtl/cdiv_bank_chk.sv
module cdiv_bank_chk #(
  parameter int NUM_DIV  = 2,
  parameter int HALF_SRC = 1
) (
  input logic               clk_ref,
  input logic               rst_n,
  input logic               clr_req,
  input logic               ratio_err,
  input logic               half_clk,
  input logic [NUM_DIV-1:0] en,
  input logic [NUM_DIV-1:0] div_clk
);
  logic src_d1, src_d2, half_d, en_d;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      src_d1 <= 1'b0;
      src_d2 <= 1'b0;
      half_d <= 1'b0;
      en_d   <= 1'b0;
    end else begin
      src_d1 <= div_clk[HALF_SRC];
      src_d2 <= src_d1;
      half_d <= half_clk;
      en_d   <= en[HALF_SRC];
    end
  end

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_ch
    logic [3:0] hi_run;
    always_ff @(posedge clk_ref) begin
      if (!rst_n) hi_run <= '0;
      else if (!div_clk[i]) hi_run <= '0;
      else if (hi_run != 4'hF) hi_run <= hi_run + 4'd1;
    end

    // R8: a gated output goes low on the next cycle
    a_r8_gate_low: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !en[i] |=> !div_clk[i]);

    // R8: re-enabling starts with a high phase
    a_r8_restart_high: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(en[i]) |=> div_clk[i]);

    // R5: a high phase of a running output is never a runt
    a_r5_no_runt: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($fell(div_clk[i]) && $past(en[i])) |-> (hi_run >= 4'd2 && hi_run <= 4'd4));
  end

  // R6: the error flag holds until a clear request
  a_r6_err_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ratio_err && !clr_req) |=> ratio_err);

  // R9: companion toggles only after a rising edge of its source
  a_r9_half_follows: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ((half_clk != half_d) && en_d) |-> (src_d1 && !src_d2));

  // R9: companion is held low while its source is gated
  a_r9_half_gated: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !en[HALF_SRC] |=> !half_clk);
endmodule

bind cdiv_bank cdiv_bank_chk #(.NUM_DIV(NUM_DIV), .HALF_SRC(HALF_SRC)) u_cdiv_chk (
  .clk_ref   (clk_ref),
  .rst_n     (rst_n),
  .clr_req   (reg_wr && (reg_addr == cdiv_pkg::CTRL_ADDR) && reg_wdata[31]),
  .ratio_err (ratio_err),
  .half_clk  (half_clk),
  .en        (en_w),
  .div_clk   (div_clk)
);

// File: tb/test_cdiv_bank.sv
module test_cdiv_bank;
  localparam int NUM_DIV = 2;
  localparam logic [31:0] EN_ALL = 32'h0300_0000;

  logic              clk_ref = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [3:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [NUM_DIV-1:0] div_clk;
  logic              half_clk;
  logic              ratio_err;

  int checks = 0;
  int errors = 0;

  always #10 clk_ref = ~clk_ref;

  cdiv_bank #(.NUM_DIV(NUM_DIV), .HALF_SRC(1)) i_cdiv_bank (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .div_clk   (div_clk),
    .half_clk  (half_clk),
    .ratio_err (ratio_err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_ref);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_ref);
    reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_ref);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 4'h0;
  endtask

  function automatic logic sig(input int ch);
    return (ch < 0) ? half_clk : div_clk[ch];
  endfunction

  task automatic measure(input int ch, output int hi, output int lo);
    @(negedge clk_ref);
    while (sig(ch)) @(negedge clk_ref);
    while (!sig(ch)) @(negedge clk_ref);
    hi = 0;
    while (sig(ch)) begin hi++; @(negedge clk_ref); end
    lo = 0;
    while (!sig(ch)) begin lo++; @(negedge clk_ref); end
  endtask

  task automatic expect_wave(input string req, input int ch, input int ehi, input int elo);
    int hi, lo;
    measure(ch, hi, lo);
    check({req, " high phase"}, hi, ehi);
    check({req, " low phase"}, lo, elo);
  endtask

  task automatic do_reload(input logic [31:0] ratio_word, input logic [7:0] force_mask);
    wr(4'h8, ratio_word);
    wr(4'h0, EN_ALL | {24'd0, force_mask});
    wr(4'h0, EN_ALL | 32'h100 | {24'd0, force_mask});
    wr(4'h0, EN_ALL);
    repeat (40) @(negedge clk_ref);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); check("R1 control reset", d, EN_ALL);
    rd(4'h8, d); check("R1 ratio reset", d, 32'h0000_0808);
    check("R1 error reset", ratio_err, 0);
    expect_wave("R1 R2 out1 ratio 8", 1, 4, 4);
    expect_wave("R1 R2 out0 ratio 8", 0, 4, 4);
  endtask

  task automatic t_stage_only;
    logic [31:0] d;
    wr(4'h8, 32'h0000_0405);
    repeat (30) @(negedge clk_ref);
    expect_wave("R3 staged not applied", 1, 4, 4);
    rd(4'h8, d); check("R3 R10 ratio readback", d, 32'h0000_0405);
  endtask

  task automatic t_reload_masked;
    logic [31:0] d;
    do_reload(32'h0000_0405, 8'h02);
    expect_wave("R4 R7 forced out1 ratio 4", 1, 2, 2);
    expect_wave("R4 unforced out0 keeps 8", 0, 4, 4);
    rd(4'h0, d); check("R7 force and reload cleared", d, EN_ALL);
  endtask

  task automatic t_odd_ratio;
    do_reload(32'h0000_0505, 8'h03);
    expect_wave("R2 out1 ratio 5", 1, 2, 3);
    expect_wave("R2 out0 ratio 5", 0, 2, 3);
  endtask

  task automatic t_ratio6;
    do_reload(32'h0000_0605, 8'h02);
    expect_wave("R2 out1 ratio 6", 1, 3, 3);
    expect_wave("R9 half of ratio 6", -1, 6, 6);
  endtask

  task automatic t_illegal;
    logic [31:0] d;
    do_reload(32'h0000_0705, 8'h02);
    expect_wave("R6 illegal keeps ratio 6", 1, 3, 3);
    check("R6 error flag set", ratio_err, 1);
    rd(4'h0, d); check("R6 error bit readback", d, EN_ALL | 32'h8000_0000);
    wr(4'h0, EN_ALL);
    check("R6 error sticky without clear", ratio_err, 1);
    wr(4'h0, EN_ALL | 32'h8000_0000);
    check("R6 error cleared", ratio_err, 0);
  endtask

  task automatic t_period_end;
    int run, bad;
    logic prev, first;
    wr(4'h8, 32'h0000_0405);
    wr(4'h0, EN_ALL | 32'h2);
    wr(4'h0, EN_ALL | 32'h102);
    prev = div_clk[1]; run = 1; bad = 0; first = 1'b1;
    repeat (60) begin
      @(negedge clk_ref);
      if (div_clk[1] == prev) run++;
      else begin
        if (!first && (run < 2 || run > 3)) bad++;
        first = 1'b0; prev = div_clk[1]; run = 1;
      end
    end
    check("R5 phases across switch 6 to 4", bad, 0);
    wr(4'h0, EN_ALL);
    expect_wave("R5 new ratio 4 applied", 1, 2, 2);
  endtask

  task automatic t_gate;
    int hi1, hh, tog0;
    logic p0;
    wr(4'h0, 32'h0100_0000);
    repeat (3) @(negedge clk_ref);
    hi1 = 0; hh = 0; tog0 = 0; p0 = div_clk[0];
    repeat (20) begin
      @(negedge clk_ref);
      if (div_clk[1]) hi1++;
      if (half_clk) hh++;
      if (div_clk[0] != p0) tog0++;
      p0 = div_clk[0];
    end
    check("R8 gated output low", hi1, 0);
    check("R9 companion low when gated", hh, 0);
    check("R8 other output keeps running", tog0 > 0, 1);
    wr(4'h0, EN_ALL);
    check("R8 still low on enable cycle", div_clk[1], 0);
    @(negedge clk_ref);
    hi1 = 0;
    while (div_clk[1]) begin hi1++; @(negedge clk_ref); end
    check("R8 full high phase after enable", hi1, 2);
  endtask

  task automatic t_half8;
    do_reload(32'h0000_0805, 8'h02);
    expect_wave("R2 out1 ratio 8", 1, 4, 4);
    expect_wave("R9 half of ratio 8", -1, 8, 8);
  endtask

  task automatic t_bad_addr;
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R10 control untouched", d, EN_ALL);
    rd(4'h8, d); check("R10 ratio untouched", d, 32'h0000_0805);
    rd(4'h4, d); check("R10 unmapped reads zero", d, 0);
    rd(4'hC, d); check("R10 unmapped reads zero", d, 0);
    expect_wave("R10 output unchanged", 1, 4, 4);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = '0;
    repeat (3) @(negedge clk_ref);
    check("R1 outputs low in reset", {30'd0, div_clk}, 0);
    check("R1 companion low in reset", half_clk, 0);
    rst_n = 1'b1;
    t_reset();
    t_stage_only();
    t_reload_masked();
    t_odd_ratio();
    t_ratio6();
    t_illegal();
    t_period_end();
    t_gate();
    t_half8();
    t_bad_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule